// File: doc/BRIEF.md
# Zoned External Memory Bus Controller

This controller connects a processor core to asynchronous external memories and peripherals. The core presents one request at a time: an address, a direction, write data and a valid flag. The three most significant address bits pick one of eight zones. Each zone has its own lead, active and trail lengths. During lead, the chip select and address settle. During active, the read or write strobe is held low. During trail, the select and strobes are released and the address is still held. A per-zone ready input can stretch the active phase. That input is sampled either directly or through a two-stage synchronizer.

There are only three chip-select outputs. Zones 0 and 1 share one, zone 2 has its own, and zones 6 and 7 share the third. Zone 7 is external only while a zone-7 enable bit is set. That bit loads from a mode pin on the first clock after reset, and software can rewrite it later. A request to a zone with no external path completes at once, with no bus cycle.

An external master can take the bus with an active-low hold request. The controller first finishes the access in flight and any request already waiting. It then grants with an active-low acknowledge and drops its drive enable, which floats the bus. The block also produces an external clock equal to the system clock divided by 1, 2 or 4, or held low.

Top module: `emif_zone_ctrl`

## Requirements
- R1: After a request is accepted at a clock edge, its chip select is low for lead+active cycles and its strobe is low for active cycles. `rsp_valid` is high in cycle lead+active+trail+1 counted from that edge. For reads, `rsp_rdata` carries `ext_rdata` as it stood in the last active cycle.
- R2: A programmed lead or active length of 0 behaves as 1. A trail length of 0 returns to idle straight after the active phase.
- R3: `rd_n` and `wr_n` are never low together. Only `rd_n` pulses on a read, and only `wr_n` pulses on a write.
- R4: `rnw` is high at rest and during reads. It is low only in the lead and active phases of a write. `ext_addr` holds the request address, and `ext_wdata` holds the write data while `wr_n` is low.
- R5: Address bits [ADDR_W-1:ADDR_W-3] give the zone. Zones 0 and 1 use `cs_n[0]`, zone 2 uses `cs_n[1]`, and zones 6 and 7 use `cs_n[2]`. At most one select is low at a time. Zones 3, 4 and 5 have no external path: such a request raises `rsp_valid` one cycle after acceptance, with no select or strobe, and reads return 0.
- R6: When `cfg_rdy_use` is set for a zone and `cfg_rdy_async` is clear, the active phase ends only at a clock edge where `ext_ready` is 1 and the programmed active count has elapsed.
- R7: When `cfg_rdy_async` is also set, `ext_ready` passes through two flops first. A ready that rises during a stretched active phase therefore ends it two cycles later than in the direct mode.
- R8: While `hold_req_n` is low, the bus is granted only from idle with no request waiting. The access in flight and a request presented in the same cycle both complete first. While granted, `hold_ack_n` and `bus_oe` are low, `req_ready` is low, and all selects are high.
- R9: `hold_ack_n` stays low as long as `hold_req_n` stays low. It returns high, and drive resumes, one cycle after `hold_req_n` goes high.
- R10: The zone-7 enable loads `mode_pin` on the first clock after reset. Later changes of `mode_pin` have no effect. A `cfg_z7_wr` pulse loads `cfg_z7_val`. While the enable is clear, zone 7 behaves like an unmapped zone.
- R11: `clk_out` equals `clk` when `cfg_clk_div`=0. It runs at one half of `clk` when the setting is 1 and one quarter when it is 2. It is held low when `cfg_clk_off` is 1.
- R12: The chip select is high in the trail phase. It never changes while a strobe is low.
- R13: After reset, all selects and strobes are high, `rnw`, `hold_ack_n`, `bus_oe` and `req_ready` are high, and `rsp_valid` is low. `rsp_valid` pulses only in an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_pin | input | 1 | Zone-7 enable value loaded after reset |
| cfg_lead | input | 8*CNT_W | Lead length per zone, zone z at [z*CNT_W +: CNT_W] |
| cfg_active | input | 8*CNT_W | Active length per zone |
| cfg_trail | input | 8*CNT_W | Trail length per zone |
| cfg_rdy_use | input | 8 | Per zone: wait for ready in the active phase |
| cfg_rdy_async | input | 8 | Per zone: take ready through the synchronizer |
| cfg_clk_div | input | 2 | External clock divide: 0 = /1, 1 = /2, 2 = /4 |
| cfg_clk_off | input | 1 | Hold the external clock low |
| cfg_z7_wr | input | 1 | Load pulse for the zone-7 enable |
| cfg_z7_val | input | 1 | Value for the zone-7 enable |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle; a request is taken at this edge |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data |
| ext_addr | output | ADDR_W | External address |
| ext_wdata | output | DATA_W | External write data |
| ext_rdata | input | DATA_W | External read data |
| ext_ready | input | 1 | External ready, high = ready |
| cs_n | output | 3 | Active-low selects: zones 0/1, zone 2, zones 6/7 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rnw | output | 1 | Read-not-write |
| bus_oe | output | 1 | Drive enable for address, select and strobe pads |
| data_oe | output | 1 | Drive enable for write-data pads |
| hold_req_n | input | 1 | Active-low bus hold request |
| hold_ack_n | output | 1 | Active-low bus hold acknowledge |
| clk_out | output | 1 | Divided external clock |

## Verification
Every result is tied to the acceptance edge. The bench presents a request at a falling edge, so acceptance happens at the next rising edge. It then samples the outputs at each later falling edge, counting select-low, strobe-low and write-direction cycles. The completion pulse is due at sample lead+active+trail+1, or at sample 1 for a zone with no external path. The ready cases raise `ext_ready` at the falling edge where the strobe count reaches a chosen value. The strobe then ends at that value in direct mode and two samples later through the synchronizer. Hold grant and release, zone-7 enable changes and divider settings are each sampled one falling edge after the rising edge that registers them.

// File: rtl/emif_pkg.sv
package emif_pkg;

  localparam int NZONE = 8;
  localparam int NCS   = 3;
  localparam int ZW    = $clog2(NZONE);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ACT,
    ST_TRAIL,
    ST_HOLD
  } bus_st_e;

  // Select index per zone; NCS marks a zone with no external path.
  function automatic logic [1:0] zone_sel(input logic [ZW-1:0] z);
    case (z)
      3'd0, 3'd1: zone_sel = 2'd0;
      3'd2:       zone_sel = 2'd1;
      3'd6, 3'd7: zone_sel = 2'd2;
      default:    zone_sel = 2'(NCS);
    endcase
  endfunction

endpackage

// File: rtl/emif_rdy_sync.sv
module emif_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/emif_clkdiv.sv
module emif_clkdiv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       off,
  output logic       clk_out
);
  logic [1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 2'd1;
  end

  always_comb begin
    if (off)                 clk_out = 1'b0;
    else if (div_sel == 2'd0) clk_out = clk;
    else if (div_sel == 2'd1) clk_out = cnt_q[0];
    else                     clk_out = cnt_q[1];
  end
endmodule

// File: rtl/emif_seq.sv
module emif_seq
  import emif_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_pin,
  input  logic [NZONE*CNT_W-1:0] cfg_lead,
  input  logic [NZONE*CNT_W-1:0] cfg_active,
  input  logic [NZONE*CNT_W-1:0] cfg_trail,
  input  logic [NZONE-1:0]       cfg_rdy_use,
  input  logic [NZONE-1:0]       cfg_rdy_async,
  input  logic                   cfg_z7_wr,
  input  logic                   cfg_z7_val,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  input  logic                   rdy_raw,
  input  logic                   rdy_sync,
  input  logic [DATA_W-1:0]      ext_rdata,
  output logic [ADDR_W-1:0]      ext_addr,
  output logic [DATA_W-1:0]      ext_wdata,
  output logic [NCS-1:0]         cs_n,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   rnw,
  output logic                   bus_oe,
  output logic                   data_oe,
  input  logic                   hold_req_n,
  output logic                   hold_ack_n
);
  bus_st_e             st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [ZW-1:0]       zone_q, zone_d;
  logic                wr_q, wr_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                rsp_q, rsp_d;
  logic                z7_q, z7_d;
  logic                init_q;

  logic [ZW-1:0]    req_zone;
  logic [CNT_W-1:0] lead_sel, act_sel, trail_sel;
  logic [CNT_W-1:0] lead_m1, act_m1;
  logic             req_mapped, rdy_ok, in_cyc;
  logic [1:0]       sel_idx;

  assign req_zone   = req_addr[ADDR_W-1 -: ZW];
  assign lead_sel   = cfg_lead[req_zone*CNT_W +: CNT_W];
  assign act_sel    = cfg_active[zone_q*CNT_W +: CNT_W];
  assign trail_sel  = cfg_trail[zone_q*CNT_W +: CNT_W];
  assign lead_m1    = (lead_sel == '0) ? '0 : lead_sel - 1'b1;
  assign act_m1     = (act_sel == '0) ? '0 : act_sel - 1'b1;
  assign req_mapped = (zone_sel(req_zone) != 2'(NCS)) &&
                      ((req_zone != ZW'(NZONE-1)) || z7_q);
  assign rdy_ok     = !cfg_rdy_use[zone_q] ||
                      (cfg_rdy_async[zone_q] ? rdy_sync : rdy_raw);

  // Zone-7 enable: pin value on the first edge after reset, software after.
  assign z7_d = !init_q ? mode_pin : (cfg_z7_wr ? cfg_z7_val : z7_q);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    zone_d  = zone_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    rsp_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          zone_d  = req_zone;
          wr_d    = req_write;
          addr_d  = req_addr;
          wdata_d = req_wdata;
          if (req_mapped) begin
            st_d  = ST_LEAD;
            cnt_d = lead_m1;
          end else begin
            rsp_d = 1'b1;
            if (!req_write) rdata_d = '0;
          end
        end else if (!hold_req_n) begin
          st_d = ST_HOLD;
        end
      end
      ST_LEAD: begin
        if (cnt_q == '0) begin
          st_d  = ST_ACT;
          cnt_d = act_m1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_ACT: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (rdy_ok) begin
          if (!wr_q) rdata_d = ext_rdata;
          if (trail_sel == '0) begin
            st_d  = ST_IDLE;
            rsp_d = 1'b1;
          end else begin
            st_d  = ST_TRAIL;
            cnt_d = trail_sel - 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (cnt_q == '0) begin
          st_d  = ST_IDLE;
          rsp_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (hold_req_n) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      zone_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
      z7_q    <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      zone_q  <= zone_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      rsp_q   <= rsp_d;
      z7_q    <= z7_d;
      init_q  <= 1'b1;
    end
  end

  assign in_cyc  = (st_q == ST_LEAD) || (st_q == ST_ACT);
  assign sel_idx = zone_sel(zone_q);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = !(in_cyc && (sel_idx == 2'(g)));
  end

  assign rd_n       = !((st_q == ST_ACT) && !wr_q);
  assign wr_n       = !((st_q == ST_ACT) && wr_q);
  assign rnw        = !(in_cyc && wr_q);
  assign data_oe    = wr_q && (in_cyc || (st_q == ST_TRAIL));
  assign bus_oe     = (st_q != ST_HOLD);
  assign hold_ack_n = (st_q != ST_HOLD);
  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign ext_addr   = addr_q;
  assign ext_wdata  = wdata_q;
endmodule

// File: rtl/emif_zone_ctrl.sv
module emif_zone_ctrl
  import emif_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_pin,
  input  logic [NZONE*CNT_W-1:0] cfg_lead,
  input  logic [NZONE*CNT_W-1:0] cfg_active,
  input  logic [NZONE*CNT_W-1:0] cfg_trail,
  input  logic [NZONE-1:0]       cfg_rdy_use,
  input  logic [NZONE-1:0]       cfg_rdy_async,
  input  logic [1:0]             cfg_clk_div,
  input  logic                   cfg_clk_off,
  input  logic                   cfg_z7_wr,
  input  logic                   cfg_z7_val,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      ext_addr,
  output logic [DATA_W-1:0]      ext_wdata,
  input  logic [DATA_W-1:0]      ext_rdata,
  input  logic                   ext_ready,
  output logic [NCS-1:0]         cs_n,
  output logic                   rd_n,
  output logic                   wr_n,
  output logic                   rnw,
  output logic                   bus_oe,
  output logic                   data_oe,
  input  logic                   hold_req_n,
  output logic                   hold_ack_n,
  output logic                   clk_out
);
  logic rdy_synced;

  emif_rdy_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_ready),
    .q     (rdy_synced)
  );

  emif_clkdiv u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (cfg_clk_div),
    .off     (cfg_clk_off),
    .clk_out (clk_out)
  );

  emif_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_pin      (mode_pin),
    .cfg_lead      (cfg_lead),
    .cfg_active    (cfg_active),
    .cfg_trail     (cfg_trail),
    .cfg_rdy_use   (cfg_rdy_use),
    .cfg_rdy_async (cfg_rdy_async),
    .cfg_z7_wr     (cfg_z7_wr),
    .cfg_z7_val    (cfg_z7_val),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rdy_raw       (ext_ready),
    .rdy_sync      (rdy_synced),
    .ext_rdata     (ext_rdata),
    .ext_addr      (ext_addr),
    .ext_wdata     (ext_wdata),
    .cs_n          (cs_n),
    .rd_n          (rd_n),
    .wr_n          (wr_n),
    .rnw           (rnw),
    .bus_oe        (bus_oe),
    .data_oe       (data_oe),
    .hold_req_n    (hold_req_n),
    .hold_ack_n    (hold_ack_n)
  );
endmodule

// File: rtl/emif_zone_ctrl_chk.sv
module emif_zone_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       rnw,
  input logic       bus_oe,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       hold_req_n,
  input logic       hold_ack_n
);
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r4_rnw_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> rnw);

  a_r4_rnw_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !rnw);

  a_r4_rnw_rest: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> rnw);

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r12_select_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> ($stable(cs_n) && !(&cs_n)));

  a_r8_hold_float: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack_n |-> (!bus_oe && !req_ready && (&cs_n)));

  a_r8_grant_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> ($past(req_ready) && !$past(hold_req_n)));

  a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack_n && !hold_req_n) |=> !hold_ack_n);

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> $past(hold_req_n));

  a_r13_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

bind emif_zone_ctrl emif_zone_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .rnw        (rnw),
  .bus_oe     (bus_oe),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .hold_req_n (hold_req_n),
  .hold_ack_n (hold_ack_n)
);

// File: tb/tb_emif_zone_ctrl.sv
`timescale 1ns/1ps
module tb_emif_zone_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n, mode_pin;
  logic [8*CW-1:0] cfg_lead, cfg_active, cfg_trail;
  logic [7:0]    cfg_rdy_use, cfg_rdy_async;
  logic [1:0]    cfg_clk_div;
  logic          cfg_clk_off, cfg_z7_wr, cfg_z7_val;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata, ext_rdata;
  logic          ext_ready;
  logic [2:0]    cs_n;
  logic          rd_n, wr_n, rnw, bus_oe, data_oe;
  logic          hold_req_n, hold_ack_n, clk_out;

  always #2.5 clk = ~clk;

  emif_zone_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int ck_edges = 0;
  always @(posedge clk_out) ck_edges++;

  typedef struct packed {
    logic [2:0] zone;
    logic       wr;
    logic [3:0] l;
    logic [3:0] a;
    logic [3:0] t;
    logic [1:0] cs;   // 3 = no external path
    logic [7:0] lat;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{3'd0, 1'b0, 4'd2,  4'd3,  4'd1,  2'd0, 8'd7},
    '{3'd1, 1'b1, 4'd1,  4'd1,  4'd0,  2'd0, 8'd3},
    '{3'd2, 1'b0, 4'd3,  4'd2,  4'd2,  2'd1, 8'd8},
    '{3'd6, 1'b1, 4'd0,  4'd0,  4'd0,  2'd2, 8'd3},
    '{3'd7, 1'b0, 4'd1,  4'd4,  4'd3,  2'd2, 8'd9},
    '{3'd3, 1'b0, 4'd2,  4'd2,  4'd2,  2'd3, 8'd1},
    '{3'd5, 1'b1, 4'd1,  4'd1,  4'd1,  2'd3, 8'd1},
    '{3'd2, 1'b1, 4'd15, 4'd15, 4'd15, 2'd1, 8'd46}
  };

  // measurements of the last access
  int m_lat, m_rd, m_wr, m_rnwlo, m_ack, m_bad_addr, m_bad_data;
  int m_cs [3];
  logic [DW-1:0] m_rdata;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic set_timing(input logic [3:0] l, input logic [3:0] a, input logic [3:0] t);
    cfg_lead   = {8{l}};
    cfg_active = {8{a}};
    cfg_trail  = {8{t}};
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    mode_pin = pin;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic z7_write(input logic v);
    @(negedge clk);
    cfg_z7_wr = 1'b1; cfg_z7_val = v;
    @(negedge clk);
    cfg_z7_wr = 1'b0;
  endtask

  task automatic do_access(input logic [2:0] zone, input logic wr, input logic [11:0] low,
                           input logic [DW-1:0] wd, input int rdy_at, input int hold_at);
    logic [AW-1:0] a;
    bit done;
    a = {zone, 1'b0, low};
    m_lat = 0; m_rd = 0; m_wr = 0; m_rnwlo = 0; m_ack = 0;
    m_bad_addr = 0; m_bad_data = 0; m_rdata = '0;
    for (int g = 0; g < 3; g++) m_cs[g] = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    if (hold_at == 0) hold_req_n = 1'b0;
    chk("R13 req_ready when idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    done = 0;
    while (!done && m_lat < 200) begin
      m_lat++;
      for (int g = 0; g < 3; g++) if (!cs_n[g]) m_cs[g]++;
      if (!rd_n) m_rd++;
      if (!wr_n) m_wr++;
      if (!rnw) m_rnwlo++;
      if (!hold_ack_n) m_ack++;
      if ((!rd_n || !wr_n) && ext_addr != a) m_bad_addr++;
      if (!wr_n && (ext_wdata != wd || !data_oe)) m_bad_data++;
      if (rdy_at != 0 && (m_rd + m_wr) == rdy_at) ext_ready = 1'b1;
      if (hold_at > 0 && m_lat == hold_at) hold_req_n = 1'b0;
      if (rsp_valid) begin
        m_rdata = rsp_rdata;
        done = 1;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_pin = 1'b1;
    set_timing(4'd1, 4'd1, 4'd0);
    cfg_rdy_use = '0; cfg_rdy_async = '0;
    cfg_clk_div = 2'd0; cfg_clk_off = 1'b0;
    cfg_z7_wr = 1'b0; cfg_z7_val = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    ext_rdata = '0; ext_ready = 1'b1; hold_req_n = 1'b1;

    do_reset(1'b1);
    // R13 reset state
    chk("R13 cs_n after reset", int'(cs_n), 7);
    chk("R13 rd_n after reset", int'(rd_n), 1);
    chk("R13 wr_n after reset", int'(wr_n), 1);
    chk("R13 rnw after reset", int'(rnw), 1);
    chk("R13 hold_ack_n after reset", int'(hold_ack_n), 1);
    chk("R13 bus_oe after reset", int'(bus_oe), 1);
    chk("R13 rsp_valid after reset", int'(rsp_valid), 0);

    // vector table: R1 R2 R3 R4 R5 R12
    for (int i = 0; i < 8; i++) begin
      int el, ea, csc, stc;
      vec_t v;
      v = VT[i];
      el  = (v.l == 0) ? 1 : int'(v.l);
      ea  = (v.a == 0) ? 1 : int'(v.a);
      csc = (v.cs == 2'd3) ? 0 : el + ea;
      stc = (v.cs == 2'd3) ? 0 : ea;
      set_timing(v.l, v.a, v.t);
      ext_rdata = 16'hC000 + 16'(i);
      do_access(v.zone, v.wr, 12'h0A0 + 12'(i), 16'h3300 + 16'(i), 0, -1);
      chk($sformatf("R1 R2 latency vec %0d", i), m_lat, int'(v.lat));
      for (int g = 0; g < 3; g++)
        chk($sformatf("R5 R12 select %0d cycles vec %0d", g, i), m_cs[g],
            (g == int'(v.cs)) ? csc : 0);
      chk($sformatf("R1 R3 read strobe vec %0d", i), m_rd, v.wr ? 0 : stc);
      chk($sformatf("R1 R3 write strobe vec %0d", i), m_wr, v.wr ? stc : 0);
      chk($sformatf("R4 rnw low cycles vec %0d", i), m_rnwlo, v.wr ? csc : 0);
      chk($sformatf("R4 address/data faults vec %0d", i), m_bad_addr + m_bad_data, 0);
      if (!v.wr)
        chk($sformatf("R1 R5 read data vec %0d", i), int'(m_rdata),
            (v.cs == 2'd3) ? 0 : int'(16'hC000 + 16'(i)));
    end

    // R6: direct ready, L1 A2 T1, ready rises when 5 strobe cycles seen
    set_timing(4'd1, 4'd2, 4'd1);
    cfg_rdy_use = 8'h01;
    ext_ready = 1'b0;
    repeat (4) @(negedge clk);
    do_access(3'd0, 1'b0, 12'h011, 16'h0, 5, -1);
    chk("R6 direct ready strobe length", m_rd, 5);
    chk("R6 direct ready latency", m_lat, 8);

    // R7: synchronised ready adds two cycles
    ext_ready = 1'b0;
    cfg_rdy_async = 8'h01;
    repeat (4) @(negedge clk);
    do_access(3'd0, 1'b0, 12'h012, 16'h0, 5, -1);
    chk("R7 synced ready strobe length", m_rd, 7);
    chk("R7 synced ready latency", m_lat, 10);
    cfg_rdy_use = '0; cfg_rdy_async = '0;
    ext_ready = 1'b1;

    // R8: hold raised with a request in the same cycle: request served first
    set_timing(4'd2, 4'd3, 4'd1);
    do_access(3'd2, 1'b1, 12'h055, 16'hBEEF, 0, 0);
    chk("R8 pending access completes", m_lat, 7);
    chk("R8 no grant during access", m_ack, 0);
    @(negedge clk);
    chk("R8 grant after drain", int'(hold_ack_n), 0);
    chk("R8 bus released", int'(bus_oe), 1 - 1);
    // request during hold must not start a cycle
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0001;
    begin
      int started = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (cs_n != 3'b111 || req_ready) started++;
      end
      chk("R8 no access while granted", started, 0);
    end
    req_valid = 1'b0;
    chk("R9 grant kept while requested", int'(hold_ack_n), 0);
    hold_req_n = 1'b1;
    @(negedge clk);
    chk("R9 grant released", int'(hold_ack_n), 1);
    chk("R9 drive resumes", int'(bus_oe), 1);

    // R10: pin changes after reset are ignored; software clears and sets
    set_timing(4'd1, 4'd1, 4'd0);
    mode_pin = 1'b0;
    do_access(3'd7, 1'b0, 12'h007, 16'h0, 0, -1);
    chk("R10 pin ignored after reset", m_cs[2], 2);
    z7_write(1'b0);
    do_access(3'd7, 1'b0, 12'h007, 16'h0, 0, -1);
    chk("R10 software clear latency", m_lat, 1);
    chk("R10 software clear no select", m_cs[2], 0);
    do_reset(1'b0);
    do_access(3'd7, 1'b1, 12'h007, 16'h1, 0, -1);
    chk("R10 pin low at reset", m_wr + m_cs[2], 0);
    z7_write(1'b1);
    do_access(3'd7, 1'b1, 12'h007, 16'h1, 0, -1);
    chk("R10 software set enables", m_cs[2], 2);
    chk("R10 software set latency", m_lat, 3);

    // R11: divided clock
    for (int d = 0; d < 3; d++) begin
      int s;
      cfg_clk_div = 2'(d);
      repeat (2) @(negedge clk);
      s = ck_edges;
      repeat (16) @(negedge clk);
      chk($sformatf("R11 clk_out edges div %0d", d), ck_edges - s, 16 >> (d * 1 + (d == 2 ? 0 : 0)) );
    end
    cfg_clk_off = 1'b1;
    begin
      int s;
      repeat (2) @(negedge clk);
      s = ck_edges;
      repeat (16) @(negedge clk);
      chk("R11 clk_out off", ck_edges - s, 0);
      chk("R11 clk_out level off", int'(clk_out), 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule